// File: doc/BRIEF.md
# Four-lane serial word receiver

This block turns four serial data lanes and one forwarded clock lane back into a 28-bit parallel word. It runs on a bit-rate sampling clock and takes one bit from every lane on each rising edge, so a word takes seven sampling cycles. The clock lane carries the repeating seven-bit frame mark 1100011, received left bit first. The block uses that mark to find where each word starts. A lock flag rises once a set number of marks have arrived back to back at the expected spacing.

Each decoded word passes through two word registers before it reaches the output. The block also drives a word-rate output clock whose rising edge falls in the middle of each output word. Several input conditions have their own output rules:

- An active-low powerdown forces the outputs low.
- A data lane flagged as idle or floating reads as all ones.
- If the clock lane itself is idle, the output clock is driven high and the last valid word is held.

Top module: `swr_top`

## Requirements
- R1: Slots are numbered 0 to 6 in arrival order. Slot 0 is the bit that arrives together with the first bit of the clock-lane mark. Slot i of data lane k appears on word_q bit 7k+i.
- R2: While the receiver is locked and running, word_clk has a period of seven sampling cycles and is high for exactly half of it (3.5 cycles). It is low in the cycle that starts at the edge where word_q updates, and it rises in the middle of the fourth cycle of that word.
- R3: While pd_n is low, word_q is all zeros and word_clk is low, with no wait for a clock edge. locked is low from the first rising edge that samples pd_n low. After pd_n returns high, word_q stays zero until a new word arrives after lock is regained.
- R4: A data lane whose lane_idle bit is high reads as logic 1 in every slot, whatever its lane_d value, while the clock lane is live. Its seven bits of the word are therefore ones.
- R5: While clk_idle is high (and pd_n is high), word_clk is high. The clock lane reads as all ones, so no mark is found and word_q keeps the last word it had.
- R6: Let edge N be the edge that samples the last slot of a frame. That frame's word appears on word_q just after edge N+8, which is two word periods after its first slot, provided the following frame is also accepted.
- R7: A frame boundary is found when the last seven clock-lane bits equal 1100011, oldest first. Matches are checked only seven cycles after the previous boundary. locked rises at the edge that registers the LOCK_FRAMES-th consecutive matching frame.
- R8: If the mark is missing at an expected boundary, locked falls at that edge and word_q holds its value. The receiver then searches again. The first word output after relock is the first frame accepted while locked, shown one frame later.
- R9: After reset, word_q is zero and locked is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate sampling clock, one slot per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_n | input | 1 | Active-low powerdown |
| lane_d | input | NLANES | Serial data lanes, one bit each per cycle |
| lane_idle | input | NLANES | Per-lane idle or floating indicator |
| clk_lane | input | 1 | Forwarded clock lane carrying the frame mark |
| clk_idle | input | 1 | Clock lane idle or floating indicator |
| word_q | output | NLANES*SLOTS | Rebuilt parallel word |
| word_clk | output | 1 | Word-rate output clock, 50% duty |
| locked | output | 1 | Frame alignment established |

## Verification
The assertions assume that pd_n and clk_idle change only away from the rising clock edge. They also assume that word_q changes on its own only at accepted boundaries, so a word change seen with the clock lane live means an update edge has just passed. The stimulus drives every input shortly before the falling-edge-plus-half point of each cycle. Clock-lane marks are sent as whole seven-slot frames, and each stream starts with the clock lane either all ones or all zeros, so no partial mark can pass for a boundary. Idle masks, random data and breaks in the mark (corrupted frame, idle clock lane, powerdown) all fall on frame boundaries.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;
  typedef enum logic {ALIGN_SEARCH, ALIGN_TRACK} align_st_e;

  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/swr_lane_shift.sv
`timescale 1ns/1ps
module swr_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             idle,
  output logic [SLOTS-1:0] sr
);
  logic             bit_eff;
  logic [SLOTS-1:0] sr_nxt;

  // failsafe: a floating input reads as one
  always_comb begin
    bit_eff = ser_in | idle;
    sr_nxt  = {sr[SLOTS-2:0], bit_eff};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end
endmodule

// File: rtl/swr_frame_align.sv
`timescale 1ns/1ps
module swr_frame_align
  import swr_pkg::*;
#(
  parameter int unsigned      SLOTS       = 7,
  parameter int unsigned      LOCK_FRAMES = 3,
  parameter logic [SLOTS-1:0] CLK_PAT     = 7'b1100011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [SLOTS-1:0] csr,
  output logic             frame_seen,
  output logic             accept,
  output logic             miss,
  output logic             locked
);
  localparam int unsigned PW = cw(SLOTS);
  localparam int unsigned KW = cw(LOCK_FRAMES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(SLOTS - 1);
  localparam logic [KW-1:0] K_LOCK  = KW'(LOCK_FRAMES);

  align_st_e     st, st_nxt;
  logic [PW-1:0] ph, ph_nxt;
  logic [KW-1:0] run, run_nxt;
  logic          locked_nxt, match, ok;

  always_comb begin
    match      = (csr == CLK_PAT);
    st_nxt     = st;
    ph_nxt     = ph;
    run_nxt    = run;
    frame_seen = 1'b0;
    ok         = 1'b0;
    miss       = 1'b0;
    if (!pd_n) begin
      st_nxt  = ALIGN_SEARCH;
      ph_nxt  = '0;
      run_nxt = '0;
    end else begin
      unique case (st)
        ALIGN_SEARCH: begin
          if (match) begin
            st_nxt     = ALIGN_TRACK;
            ph_nxt     = '0;
            run_nxt    = KW'(1);
            frame_seen = 1'b1;
          end
        end
        ALIGN_TRACK: begin
          if (ph == PH_LAST) begin
            ph_nxt = '0;
            if (match) begin
              ok         = 1'b1;
              frame_seen = 1'b1;
              if (run < K_LOCK) run_nxt = run + KW'(1);
            end else begin
              miss    = 1'b1;
              st_nxt  = ALIGN_SEARCH;
              run_nxt = '0;
            end
          end else begin
            ph_nxt = ph + PW'(1);
          end
        end
        default: st_nxt = ALIGN_SEARCH;
      endcase
    end
    locked_nxt = (run_nxt >= K_LOCK);
    accept     = ok & locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ALIGN_SEARCH;
      ph     <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else begin
      st     <= st_nxt;
      ph     <= ph_nxt;
      run    <= run_nxt;
      locked <= locked_nxt;
    end
  end
endmodule

// File: rtl/swr_word_out.sv
`timescale 1ns/1ps
module swr_word_out
  import swr_pkg::*;
#(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned SLOTS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              clk_idle,
  input  logic              frame_seen,
  input  logic              accept,
  input  logic              miss,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q,
  output logic              word_clk
);
  localparam int unsigned CW = cw(SLOTS);
  localparam logic [CW-1:0] C_LAST = CW'(SLOTS - 1);
  localparam logic [CW-1:0] C_HALF = CW'(SLOTS / 2);

  logic [WORD_W-1:0] stg_a, word_r, word_r_nxt;
  logic              a_vld, a_vld_nxt, a_en;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic              half_q, clk_raw;

  always_comb begin
    a_en       = 1'b0;
    a_vld_nxt  = a_vld;
    word_r_nxt = word_r;
    if (!pd_n) begin
      a_vld_nxt  = 1'b0;
      word_r_nxt = '0;
    end else if (miss) begin
      a_vld_nxt = 1'b0;
    end else if (accept) begin
      a_en      = 1'b1;
      a_vld_nxt = 1'b1;
      if (a_vld) word_r_nxt = stg_a;
    end
    if (frame_seen)        cnt_nxt = '0;
    else if (cnt == C_LAST) cnt_nxt = '0;
    else                    cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      word_r <= '0;
      cnt    <= '0;
    end else begin
      a_vld  <= a_vld_nxt;
      word_r <= word_r_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stg_a <= '0;
    else if (a_en) stg_a <= word_in;
  end

  // half-cycle extension gives 50% duty on an odd divide
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= (cnt == C_HALF);
  end

  always_comb begin
    clk_raw  = (cnt > C_HALF) | half_q;
    word_clk = pd_n & (clk_idle | clk_raw);
    word_q   = pd_n ? word_r : '0;
  end
endmodule

// File: rtl/swr_top.sv
`timescale 1ns/1ps
module swr_top #(
  parameter int unsigned      NLANES      = 4,
  parameter int unsigned      SLOTS       = 7,
  parameter int unsigned      LOCK_FRAMES = 3,
  parameter logic [SLOTS-1:0] CLK_PAT     = 7'b1100011
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pd_n,
  input  logic [NLANES-1:0]       lane_d,
  input  logic [NLANES-1:0]       lane_idle,
  input  logic                    clk_lane,
  input  logic                    clk_idle,
  output logic [NLANES*SLOTS-1:0] word_q,
  output logic                    word_clk,
  output logic                    locked
);
  localparam int unsigned WORD_W = NLANES * SLOTS;

  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [SLOTS-1:0]  dsr [NLANES];
  logic [SLOTS-1:0]  csr;
  logic [WORD_W-1:0] word_in;
  logic              frame_seen, accept, miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    swr_lane_shift #(.SLOTS(SLOTS)) u_sh (
      .clk(clk), .rst_n(rst_s), .ser_in(lane_d[k]),
      .idle(lane_idle[k]), .sr(dsr[k])
    );
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign word_in[k*SLOTS + i] = dsr[k][SLOTS-1-i];
    end
  end

  swr_lane_shift #(.SLOTS(SLOTS)) u_clk_sh (
    .clk(clk), .rst_n(rst_s), .ser_in(clk_lane),
    .idle(clk_idle), .sr(csr)
  );

  swr_frame_align #(
    .SLOTS(SLOTS), .LOCK_FRAMES(LOCK_FRAMES), .CLK_PAT(CLK_PAT)
  ) u_align (
    .clk(clk), .rst_n(rst_s), .pd_n(pd_n), .csr(csr),
    .frame_seen(frame_seen), .accept(accept), .miss(miss), .locked(locked)
  );

  swr_word_out #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_out (
    .clk(clk), .rst_n(rst_s), .pd_n(pd_n), .clk_idle(clk_idle),
    .frame_seen(frame_seen), .accept(accept), .miss(miss),
    .word_in(word_in), .word_q(word_q), .word_clk(word_clk)
  );
endmodule

// File: rtl/swr_top_chk.sv
`timescale 1ns/1ps
module swr_top_chk #(
  parameter int unsigned WORD_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_n,
  input logic              clk_idle,
  input logic              locked,
  input logic [WORD_W-1:0] word_q,
  input logic              word_clk
);
  AST_PD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> ((word_q == '0) && !word_clk)); // R3

  AST_PD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !locked); // R3

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && clk_idle) |-> word_clk); // R5

  AST_HOLD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !locked) |=> (!pd_n || $stable(word_q))); // R8

  AST_UPDATE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && $past(pd_n) && !clk_idle && (word_q != $past(word_q))) |-> !word_clk); // R2
endmodule

bind swr_top swr_top_chk #(.WORD_W(NLANES*SLOTS)) i_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .clk_idle(clk_idle),
  .locked(locked), .word_q(word_q), .word_clk(word_clk)
);

// File: tb/test_swr_top.sv
`timescale 1ns/1ps
module test_swr_top;
  localparam int L = 3;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst_n, pd_n, clk_lane, clk_idle;
  logic [3:0]  lane_d, lane_idle;
  logic [27:0] word_q;
  logic        word_clk, locked;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [27:0] exp_w [64];
  logic [3:0]  exp_m [64];
  logic [27:0] held;

  always #4 clk = ~clk;

  swr_top #(.LOCK_FRAMES(L)) i_swr_top (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .lane_d(lane_d),
    .lane_idle(lane_idle), .clk_lane(clk_lane), .clk_idle(clk_idle),
    .word_q(word_q), .word_clk(word_clk), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [27:0] fill(input logic [27:0] w, input logic [3:0] m);
    logic [27:0] r;
    r = w;
    for (int k = 0; k < 4; k++) if (m[k]) r[k*7 +: 7] = 7'h7f;
    return r;
  endfunction

  task automatic run_stream(input int n, input bit walk, input bit use_idle);
    logic [27:0] raw;
    logic [3:0]  m, d;
    int          hi, j;
    string       tag;
    for (int f = 0; f < n; f++) begin
      raw = (walk && f < 28) ? (28'(1) << f) : 28'($urandom);
      m   = (use_idle && ($urandom % 3 == 0)) ? 4'($urandom) : 4'h0;
      exp_w[f] = fill(raw, m);
      exp_m[f] = m;
      hi = 0;
      for (int s = 0; s < 7; s++) begin
        @(negedge clk); #2;
        if (word_clk) hi++;
        for (int k = 0; k < 4; k++) d[k] = m[k] ? 1'($urandom) : raw[k*7 + s];
        lane_d = d; lane_idle = m; clk_lane = PAT[6-s]; clk_idle = 1'b0; pd_n = 1'b1;
        @(posedge clk); #2;
        if (word_clk) hi++;
        if (s == 0) begin
          if (f == 0) begin
            chk(!locked, "R8 unlocked before realign", 32'(locked), 32'd0);
            chk(word_q == held, "R8 word held while unlocked", 32'(word_q), 32'(held));
          end else begin
            j = f - 1;
            chk(locked == (j >= L - 1), "R7 lock after consecutive marks", 32'(locked), 32'(j >= L - 1));
            if (j >= L + 1) begin
              tag = walk ? "R1 slot mapping" : ((exp_m[j-1] != 0) ? "R4 idle lane ones" : "R6 latency");
              chk(word_q == exp_w[j-1], tag, 32'(word_q), 32'(exp_w[j-1]));
            end else begin
              chk(word_q == held, "R8 no output before relock", 32'(word_q), 32'(held));
            end
            if (f >= L + 2) chk(!word_clk, "R2 clock low at update", 32'(word_clk), 32'd0);
          end
        end
      end
      if (f >= L + 2) chk(hi == 7, "R2 duty cycle", 32'(hi), 32'd7);
    end
    held = exp_w[n-2];
  endtask

  // kind 0: corrupted mark, 1: idle clock lane, 2: powerdown
  task automatic bad_frame(input int kind);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk); #2;
      lane_d    = 4'($urandom);
      lane_idle = 4'h0;
      clk_lane  = (kind == 0) ? 1'b0 : ((kind == 1) ? 1'($urandom) : 1'b1);
      clk_idle  = (kind == 1);
      pd_n      = (kind != 2);
      @(posedge clk); #2;
      if (kind == 2) begin
        chk(word_q == '0, "R3 data low in powerdown", 32'(word_q), 32'd0);
        chk(!word_clk, "R3 clock low in powerdown", 32'(word_clk), 32'd0);
        chk(!locked, "R3 lock cleared in powerdown", 32'(locked), 32'd0);
      end else begin
        chk(word_q == held, (kind == 1) ? "R5 word held, clock idle" : "R8 word held on loss",
            32'(word_q), 32'(held));
        if (kind == 1) chk(word_clk, "R5 clock high when idle", 32'(word_clk), 32'd1);
      end
    end
    if (kind == 2) held = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; pd_n = 1'b1; clk_lane = 1'b1; clk_idle = 1'b0;
    lane_d = 4'h0; lane_idle = 4'h0; held = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(word_q == '0, "R9 reset word", 32'(word_q), 32'd0);
    chk(!locked, "R9 reset lock", 32'(locked), 32'd0);
    run_stream(32, 1'b1, 1'b0);
    bad_frame(0);
    run_stream(20, 1'b0, 1'b1);
    bad_frame(1);
    run_stream(12, 1'b0, 1'b1);
    bad_frame(2);
    run_stream(10, 1'b0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule